// File: doc/BRIEF.md
# Bridge Fault Diagnosis Encoder

This block turns fault events from two motor-bridge channels into the 2-bit error code carried in the upper two bits of the serial status byte. Each channel keeps its own latched fault state: a ground-short latch set by source overcurrent, a supply-short latch set by a sink overload right after turn-on, and an open-load flag decided by a flyback-pulse check after each winding reversal. All sensing is done elsewhere. Every event arrives here as a synchronous one-cycle pulse or a level.

Each channel reduces its state to a fault class. A registered merge stage then combines the classes of both channels with the two thermal levels into one code. The code is 11 for no fault, 01 for the weakest class (open load or supply short), 10 for a ground short and 00 for any thermal condition. Faults of equal rank are ANDed together, and a higher rank always wins. The six command bits that go back in the same byte are passed through. The exception is thermal shutdown: the bridges are then forced off and the command bits read all ones.

The open-load check is not trusted until a per-channel settling filter has seen four chopping events or polarity changes. Before that, a reversal reports open load even when a flyback pulse is present. The check is skipped entirely while the channel is in hold-current or off mode.

Top module: `fault_diag_enc`

## Requirements
- R1: After synchronous reset, err_code_o reads 11, status_o reads {11, cmd_i} and bridge_off_o is all zero.
- R2: status_o[7:6] always equals err_code_o. status_o[5:0] equals cmd_i of the previous cycle unless thermal shutdown is active. A fault pulse changes the code two clock edges after it is sampled.
- R3: A source-overcurrent pulse on a channel latches a ground-short fault, giving code 10, and raises that channel's bridge_off_o bit one edge after the pulse. Both persist until a frame_end_i pulse clears them. Standby does not clear them.
- R4: A sink-short pulse latches a supply-short fault (code 01). A chopping pulse on the same channel clears it, and so does standby_i. If a sink-short pulse and a chopping pulse arrive in the same cycle, the fault is set. frame_end_i has no effect on it.
- R5: With cur_code 00 (full) or 01 (reduced), a polarity-change pulse opens a window of FLY_WIN cycles. If no flyback pulse is sampled in that window, the channel flags open load (code 01). A later window that does see a flyback pulse clears the flag.
- R6: With cur_code 10 (hold) or 11 (off), a polarity-change pulse starts no check, and no open-load fault arises from it.
- R7: A per-channel settling counter advances on each chopping or polarity-change pulse and saturates at SETTLE_CNT. Until it saturates, flyback pulses are ignored, so reversals report open load. standby_i clears the counter.
- R8: Ranking is thermal above ground short above open or supply short. Codes of equal rank from the two channels are combined by bitwise AND.
- R9: While therm_warn_i is high, the code is 00 one edge later, cmd_i is still returned, and bridge_off_o is not forced.
- R10: While therm_sd_i is high, the code is 00, status_o[5:0] reads all ones and every bridge_off_o bit is 1, each one edge after the level is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby_i | input | 1 | Standby level; clears supply-short, open-load and settling state |
| frame_end_i | input | 1 | Pulse at the end of an accepted serial frame |
| src_ovc_i | input | NCH | Source-overcurrent pulse per channel |
| sink_short_i | input | NCH | Sink overload shortly after turn-on, per channel |
| chop_i | input | NCH | Normal chopping-comparator trip per channel |
| flyback_i | input | NCH | Flyback pulse detected, per channel |
| pol_chg_i | input | NCH | Winding polarity reversal strobe per channel |
| cur_code_i | input | 2*NCH | Current code per channel: 00 full, 01 reduced, 10 hold, 11 off |
| therm_warn_i | input | 1 | Thermal prealarm level |
| therm_sd_i | input | 1 | Thermal shutdown level |
| cmd_i | input | 6 | Command bits to return in the status byte |
| err_code_o | output | 2 | Merged error code |
| status_o | output | 8 | Status byte {err_code, command bits} |
| bridge_off_o | output | NCH | Bridge forced off per channel |

## Verification
Every channel latch changes on the edge that samples its event pulse, and the registered merge moves the code and status byte one edge after that. A fault pulse therefore shows in err_code_o two edges after it is driven. The bridge_off_o bit from an overcurrent follows one edge after the pulse, and so do the code, the status byte and bridge_off_o after a thermal level. An open-load verdict is due FLY_WIN edges after the window opens, plus one edge for the merge. The scoreboard stamps each expected item with the cycle in which it falls due and compares it at the falling edge of exactly that cycle. Open-load outcomes are compared only after a margin well beyond the window has passed.

// File: rtl/fde_pkg.sv
// Shared types and helpers for the bridge fault diagnosis encoder.
// Assumes two-bit current codes and a fixed 8-bit status byte.
package fde_pkg;

    // Per-channel fault rank, lowest to highest
    typedef enum logic [1:0] {
        CLS_OK   = 2'd0,
        CLS_WEAK = 2'd1,
        CLS_GND  = 2'd2
    } fault_cls_e;

    localparam int unsigned CMD_W    = 6;
    localparam int unsigned CODE_W   = 2;
    localparam int unsigned STATUS_W = CODE_W + CMD_W;

    localparam logic [1:0] CODE_OK    = 2'b11;
    localparam logic [1:0] CODE_WEAK  = 2'b01;
    localparam logic [1:0] CODE_GND   = 2'b10;
    localparam logic [1:0] CODE_THERM = 2'b00;

    localparam logic [1:0] CUR_HOLD = 2'b10;
    localparam logic [1:0] CUR_OFF  = 2'b11;

    // Error code of one fault class
    function automatic logic [1:0] cls_code(input fault_cls_e c);
        case (c)
            CLS_GND:  return CODE_GND;
            CLS_WEAK: return CODE_WEAK;
            default:  return CODE_OK;
        endcase
    endfunction

    // True when a reversal in this current mode gets a flyback check
    function automatic logic mode_checked(input logic [1:0] cur);
        return (cur != CUR_HOLD) && (cur != CUR_OFF);
    endfunction

endpackage

// File: rtl/fde_settle.sv
// Settling filter for one channel: counts step pulses up to SETTLE_CNT
// and then reports settled. Assumes step is a one-cycle pulse.
module fde_settle #(
    parameter int unsigned SETTLE_CNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    output logic settled_o
);
    localparam int unsigned CW = $clog2(SETTLE_CNT + 1);

    logic [CW-1:0] cnt_q;

    assign settled_o = (cnt_q == CW'(SETTLE_CNT));

    // Saturating step counter, cleared by standby
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (step_i && !settled_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R7
    settle_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !settled_o);

endmodule

// File: rtl/fde_chan.sv
// One bridge channel: latches ground-short, supply-short and open-load
// faults and reports the highest fault class. Assumes all event inputs
// are synchronous single-cycle pulses.
module fde_chan
    import fde_pkg::*;
#(
    parameter int unsigned SETTLE_CNT = 4,
    parameter int unsigned FLY_WIN    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       standby_i,
    input  logic       frame_end_i,
    input  logic       src_ovc_i,
    input  logic       sink_short_i,
    input  logic       chop_i,
    input  logic       flyback_i,
    input  logic       pol_chg_i,
    input  logic [1:0] cur_i,
    output fault_cls_e cls_o,
    output logic       gnd_off_o
);
    localparam int unsigned WW = $clog2(FLY_WIN + 1);

    logic          gnd_q;
    logic          ss_q;
    logic          open_q;
    logic          seen_q;
    logic [WW-1:0] win_q;
    logic          settled;
    logic          fly_ok;
    logic          start_chk;

    fde_settle #(.SETTLE_CNT(SETTLE_CNT)) settle_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (standby_i),
        .step_i    (chop_i | pol_chg_i),
        .settled_o (settled)
    );

    assign fly_ok    = flyback_i & settled;
    assign start_chk = pol_chg_i & mode_checked(cur_i);

    // Ground-short latch: set by source overcurrent, cleared at frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnd_q <= 1'b0;
        end else if (src_ovc_i) begin
            gnd_q <= 1'b1;
        end else if (frame_end_i) begin
            gnd_q <= 1'b0;
        end
    end

    // Supply-short latch: overwritten by normal chopping or standby
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_q <= 1'b0;
        end else if (sink_short_i) begin
            ss_q <= 1'b1;
        end else if (chop_i || standby_i) begin
            ss_q <= 1'b0;
        end
    end

    // Flyback window after a checked reversal and the open-load verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= '0;
            seen_q <= 1'b0;
            open_q <= 1'b0;
        end else if (standby_i) begin
            win_q  <= '0;
            seen_q <= 1'b0;
            open_q <= 1'b0;
        end else if (start_chk) begin
            win_q  <= WW'(FLY_WIN);
            seen_q <= 1'b0;
        end else if (win_q != '0) begin
            win_q  <= win_q - 1'b1;
            seen_q <= seen_q | fly_ok;
            if (win_q == WW'(1)) begin
                open_q <= !(seen_q || fly_ok);
            end
        end
    end

    // Fault class from the latches, ground short ranked above the rest
    always_comb begin
        if (gnd_q) begin
            cls_o = CLS_GND;
        end else if (ss_q || open_q) begin
            cls_o = CLS_WEAK;
        end else begin
            cls_o = CLS_OK;
        end
    end

    assign gnd_off_o = gnd_q;

    // R3
    gnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnd_q && !frame_end_i) |=> gnd_q);

    // R5
    open_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q == WW'(1) && !seen_q && !fly_ok && !start_chk && !standby_i)
        |=> open_q);

    // R6
    hold_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_chg_i && !mode_checked(cur_i) && win_q == '0) |=> (win_q == '0));

endmodule

// File: rtl/fde_merge.sv
// Registered merge of per-channel fault classes and thermal levels into
// the error code and status byte. Assumes inputs settle within a cycle.
module fde_merge
    import fde_pkg::*;
#(
    parameter int unsigned NCH = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  fault_cls_e [NCH-1:0]      cls_i,
    input  logic                      therm_warn_i,
    input  logic                      therm_sd_i,
    input  logic [CMD_W-1:0]          cmd_i,
    output logic [CODE_W-1:0]         code_o,
    output logic [STATUS_W-1:0]       status_o,
    output logic                      sd_o
);
    logic [1:0]       gnd_and;
    logic [1:0]       weak_and;
    logic             gnd_any;
    logic             weak_any;
    logic [1:0]       code_d;
    logic [1:0]       code_q;
    logic [CMD_W-1:0] cmd_q;
    logic             sd_q;

    // AND codes within each rank and pick the highest rank present
    always_comb begin
        gnd_and  = CODE_OK;
        weak_and = CODE_OK;
        gnd_any  = 1'b0;
        weak_any = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (cls_i[i] == CLS_GND) begin
                gnd_any = 1'b1;
                gnd_and = gnd_and & cls_code(cls_i[i]);
            end else if (cls_i[i] == CLS_WEAK) begin
                weak_any = 1'b1;
                weak_and = weak_and & cls_code(cls_i[i]);
            end
        end
        if (therm_sd_i || therm_warn_i) begin
            code_d = CODE_THERM;
        end else if (gnd_any) begin
            code_d = gnd_and;
        end else if (weak_any) begin
            code_d = weak_and;
        end else begin
            code_d = CODE_OK;
        end
    end

    // Register code, returned command and shutdown state once per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= CODE_OK;
            cmd_q  <= '1;
            sd_q   <= 1'b0;
        end else begin
            code_q <= code_d;
            cmd_q  <= therm_sd_i ? '1 : cmd_i;
            sd_q   <= therm_sd_i;
        end
    end

    assign code_o   = code_q;
    assign status_o = {code_q, cmd_q};
    assign sd_o     = sd_q;

endmodule

// File: rtl/fault_diag_enc.sv
// Top of the bridge fault diagnosis encoder: one fault channel per
// bridge, a registered merge, and the per-bridge forced-off outputs.
// Assumes all inputs are synchronous to clk.
module fault_diag_enc
    import fde_pkg::*;
#(
    parameter int unsigned NCH        = 2,
    parameter int unsigned SETTLE_CNT = 4,
    parameter int unsigned FLY_WIN    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby_i,
    input  logic             frame_end_i,
    input  logic [NCH-1:0]   src_ovc_i,
    input  logic [NCH-1:0]   sink_short_i,
    input  logic [NCH-1:0]   chop_i,
    input  logic [NCH-1:0]   flyback_i,
    input  logic [NCH-1:0]   pol_chg_i,
    input  logic [2*NCH-1:0] cur_code_i,
    input  logic             therm_warn_i,
    input  logic             therm_sd_i,
    input  logic [5:0]       cmd_i,
    output logic [1:0]       err_code_o,
    output logic [7:0]       status_o,
    output logic [NCH-1:0]   bridge_off_o
);
    fault_cls_e [NCH-1:0] cls;
    logic [NCH-1:0]       gnd_off;
    logic                 sd;

    // One fault channel per bridge
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        fde_chan #(
            .SETTLE_CNT (SETTLE_CNT),
            .FLY_WIN    (FLY_WIN)
        ) chan_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .standby_i    (standby_i),
            .frame_end_i  (frame_end_i),
            .src_ovc_i    (src_ovc_i[ch]),
            .sink_short_i (sink_short_i[ch]),
            .chop_i       (chop_i[ch]),
            .flyback_i    (flyback_i[ch]),
            .pol_chg_i    (pol_chg_i[ch]),
            .cur_i        (cur_code_i[2*ch +: 2]),
            .cls_o        (cls[ch]),
            .gnd_off_o    (gnd_off[ch])
        );
    end

    fde_merge #(.NCH(NCH)) merge_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cls_i        (cls),
        .therm_warn_i (therm_warn_i),
        .therm_sd_i   (therm_sd_i),
        .cmd_i        (cmd_i),
        .code_o       (err_code_o),
        .status_o     (status_o),
        .sd_o         (sd)
    );

    assign bridge_off_o = gnd_off | {NCH{sd}};

    // R10
    therm_sd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        therm_sd_i |=> (err_code_o == CODE_THERM && status_o[5:0] == 6'h3F
                        && bridge_off_o == '1));

    // R8
    gnd_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnd_off) && !therm_warn_i && !therm_sd_i) |=> (err_code_o == CODE_GND));

    // R2
    code_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7:6] == err_code_o);

endmodule

// File: tb/fault_diag_enc_tb_top.sv
module fault_diag_enc_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam logic [5:0] CMD = 6'h13;

    typedef struct {
        int          due;
        logic [7:0]  st;
        logic [1:0]  off;
        string       tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             standby = 1'b0;
    logic             frame_end = 1'b0;
    logic [NCH-1:0]   src_ovc = '0;
    logic [NCH-1:0]   sink_short = '0;
    logic [NCH-1:0]   chop = '0;
    logic [NCH-1:0]   flyback = '0;
    logic [NCH-1:0]   pol_chg = '0;
    logic [2*NCH-1:0] cur_code = '0;
    logic             therm_warn = 1'b0;
    logic             therm_sd = 1'b0;
    logic [5:0]       cmd = CMD;
    logic [1:0]       err_code;
    logic [7:0]       status;
    logic [NCH-1:0]   bridge_off;

    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t q[$];

    fault_diag_enc dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .standby_i    (standby),
        .frame_end_i  (frame_end),
        .src_ovc_i    (src_ovc),
        .sink_short_i (sink_short),
        .chop_i       (chop),
        .flyback_i    (flyback),
        .pol_chg_i    (pol_chg),
        .cur_code_i   (cur_code),
        .therm_warn_i (therm_warn),
        .therm_sd_i   (therm_sd),
        .cmd_i        (cmd),
        .err_code_o   (err_code),
        .status_o     (status),
        .bridge_off_o (bridge_off)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares each expected item at the falling edge it is due
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].due <= cyc) begin
                exp_t it;
                it = q.pop_front();
                n_run++;
                if (it.due != cyc || status !== it.st || err_code !== it.st[7:6]
                    || bridge_off !== it.off) begin
                    n_fail++;
                    $display("FAIL %s @%0d: status=%h code=%b off=%b, expected status=%h code=%b off=%b",
                             it.tag, cyc, status, err_code, bridge_off, it.st, it.st[7:6], it.off);
                end
            end
        end
    end

    // Driver helpers
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_in(input int d, input logic [1:0] code, input logic [5:0] c,
                             input logic [1:0] off, input string tag);
        exp_t it;
        it.due = cyc + d;
        it.st  = {code, c};
        it.off = off;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic drain();
        while (q.size() > 0) tick(1);
    endtask

    task automatic chk_after(input int d, input logic [1:0] code, input logic [1:0] off,
                             input string tag);
        expect_in(d, code, CMD, off, tag);
        drain();
    endtask

    // Reversal on channel 0, optional flyback dly cycles after the strobe clears
    task automatic reverse0(input bit fly, input int dly);
        pol_chg = 2'b01;
        tick(1);
        pol_chg = '0;
        if (fly) begin
            tick(dly);
            flyback = 2'b01;
            tick(1);
            flyback = '0;
        end
        tick(16);
    endtask

    task automatic pulse_standby();
        standby = 1'b1;
        tick(1);
        standby = 1'b0;
        tick(2);
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        // R1: reset state
        chk_after(3, 2'b11, 2'b00, "R1 reset state");

        // R3 / R2: overcurrent latch timing and frame-end clear
        src_ovc = 2'b01;
        expect_in(1, 2'b11, CMD, 2'b01, "R3 bridge off one edge after");
        expect_in(2, 2'b10, CMD, 2'b01, "R2 code two edges after");
        tick(1);
        src_ovc = '0;
        drain();
        pulse_standby();
        chk_after(4, 2'b10, 2'b01, "R3 held through standby");
        frame_end = 1'b1;
        expect_in(1, 2'b10, CMD, 2'b00, "R3 bridge released at frame end");
        expect_in(2, 2'b11, CMD, 2'b00, "R3 code cleared at frame end");
        tick(1);
        frame_end = 1'b0;
        drain();

        // R4: supply short set, chop clear, frame end ignored, standby clear
        sink_short = 2'b10;
        expect_in(2, 2'b01, CMD, 2'b00, "R4 supply short");
        tick(1);
        sink_short = '0;
        drain();
        chop = 2'b10;
        expect_in(2, 2'b11, CMD, 2'b00, "R4 chop overwrites");
        tick(1);
        chop = '0;
        drain();
        sink_short = 2'b10;
        tick(1);
        sink_short = '0;
        frame_end = 1'b1;
        tick(1);
        frame_end = 1'b0;
        chk_after(3, 2'b01, 2'b00, "R4 frame end no effect");
        standby = 1'b1;
        expect_in(2, 2'b11, CMD, 2'b00, "R4 standby clears");
        tick(1);
        standby = 1'b0;
        drain();
        sink_short = 2'b01;
        chop = 2'b01;
        expect_in(2, 2'b01, CMD, 2'b00, "R4 set wins over chop");
        tick(1);
        sink_short = '0;
        chop = '0;
        drain();
        chop = 2'b01;
        tick(1);
        chop = '0;
        chk_after(2, 2'b11, 2'b00, "R4 cleared by chop");

        // R8 / R9: dominance and prealarm
        sink_short = 2'b01;
        src_ovc = 2'b10;
        expect_in(2, 2'b10, CMD, 2'b10, "R8 ground over supply short");
        tick(1);
        sink_short = '0;
        src_ovc = '0;
        drain();
        frame_end = 1'b1;
        expect_in(2, 2'b01, CMD, 2'b00, "R8 weak left after ground cleared");
        tick(1);
        frame_end = 1'b0;
        drain();
        therm_warn = 1'b1;
        expect_in(1, 2'b00, CMD, 2'b00, "R9 prealarm returns command");
        tick(1);
        src_ovc = 2'b10;
        expect_in(2, 2'b00, CMD, 2'b10, "R8 thermal over ground");
        tick(1);
        src_ovc = '0;
        drain();
        therm_warn = 1'b0;
        expect_in(1, 2'b10, CMD, 2'b10, "R9 prealarm removed");
        tick(1);
        drain();
        frame_end = 1'b1;
        tick(1);
        frame_end = 1'b0;
        chk_after(2, 2'b01, 2'b00, "R8 back to weak");
        chop = 2'b01;
        tick(1);
        chop = '0;
        chk_after(2, 2'b11, 2'b00, "R8 clean");

        // R10: thermal shutdown forces command ones and bridges off
        therm_sd = 1'b1;
        expect_in(1, 2'b00, 6'h3F, 2'b11, "R10 shutdown");
        tick(2);
        cmd = 6'h05;
        expect_in(2, 2'b00, 6'h3F, 2'b11, "R10 command masked");
        tick(2);
        drain();
        cmd = CMD;
        therm_sd = 1'b0;
        expect_in(1, 2'b11, CMD, 2'b00, "R10 shutdown removed");
        tick(1);
        drain();

        // R7: settling filter after standby reports open on first reversals
        pulse_standby();
        cur_code = 4'b0001;
        reverse0(1'b1, 2);
        chk_after(1, 2'b01, 2'b00, "R7 unsettled reversal 1");
        reverse0(1'b1, 2);
        chk_after(1, 2'b01, 2'b00, "R7 unsettled reversal 2");
        reverse0(1'b1, 2);
        chk_after(1, 2'b01, 2'b00, "R7 unsettled reversal 3");
        reverse0(1'b1, 2);
        chk_after(1, 2'b11, 2'b00, "R7 settled reversal 4");

        // R5: missing flyback, late flyback, recovery
        reverse0(1'b0, 0);
        chk_after(1, 2'b01, 2'b00, "R5 missing flyback");
        reverse0(1'b1, 2);
        chk_after(1, 2'b11, 2'b00, "R5 flyback clears");
        reverse0(1'b1, 12);
        chk_after(1, 2'b01, 2'b00, "R5 flyback after window");
        cur_code = 4'b0000;
        reverse0(1'b1, 5);
        chk_after(1, 2'b11, 2'b00, "R5 full-current check passes");

        // R6: no check in hold or off mode
        cur_code = 4'b0010;
        reverse0(1'b0, 0);
        chk_after(1, 2'b11, 2'b00, "R6 hold mode skipped");
        cur_code = 4'b0011;
        reverse0(1'b0, 0);
        chk_after(1, 2'b11, 2'b00, "R6 off mode skipped");

        // R8: equal-rank AND of open load and supply short
        cur_code = 4'b0001;
        reverse0(1'b0, 0);
        sink_short = 2'b10;
        tick(1);
        sink_short = '0;
        chk_after(2, 2'b01, 2'b00, "R8 equal rank combined");
        chop = 2'b10;
        tick(1);
        chop = '0;
        chk_after(2, 2'b01, 2'b00, "R8 open remains after chop");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule